// File: doc/BRIEF.md
# Power-Down Wake-Up Validation Monitor

This block owns the low-power state of a serial bus interface controller. The host requests low power with a one-cycle write strobe, which sets a power-down flag. While the flag is set, the clocked bus glitch filter and its microsecond timebase are frozen. Two sources end low power. The first is any falling edge on the raw bus line, caught asynchronously so that even an edge narrower than a clock period counts. The second is a high level on the host ready line. On wake-up the flag clears by itself.

A noise spike can wake the controller without any real bus traffic. So after every wake-up the block opens a validation window, measured in microseconds, and watches the now-running glitch filter. If the filtered bus goes low inside the window, the wake-up was genuine and the window closes quietly. If the window expires first, the block raises a spurious-wake pulse of fixed length and stays in run mode. The host then decides whether to write the power-down strobe again. The same path covers a host that requests power-down while its ready line is already high.

A prescaler derives the microsecond tick from the system clock. The prescaler restarts on every wake-up, so the window and pulse lengths are exact whole numbers of clock cycles.

Top module: `pdwake_monitor`

## Requirements
- R1: During and after reset, pd_bit is 0, spur_wake is 0 and bus_filt is 1 (bus idle high).
- R2: A one-cycle pd_req in run mode sets pd_bit at the next clock edge. While bus_raw stays high and host_rdy stays low, pd_bit stays 1 and bus_filt stays 1.
- R3: While pd_bit is 1, any falling edge on bus_raw, including a low glitch shorter than a clock period, clears pd_bit within SYNC_STAGES+3 clock cycles.
- R4: While pd_bit is 1, a high level on host_rdy clears pd_bit within SYNC_STAGES+3 cycles. If host_rdy is already high when pd_req is written, pd_bit is 1 for exactly one cycle.
- R5: In run mode, bus_filt takes a new bus_raw level only after that level has held for FILT_US microsecond ticks (one tick every CLK_PER_US cycles). With the bench values, a 5 µs low pulse leaves bus_filt high and a 10 µs low drives it low.
- R6: If bus_filt does not go low after pd_bit clears, spur_wake rises exactly WIN_US*CLK_PER_US cycles after pd_bit falls.
- R7: spur_wake stays high for exactly PULSE_US*CLK_PER_US cycles and then returns to 0.
- R8: If bus_filt goes low inside the validation window, no spur_wake pulse occurs for that wake-up.
- R9: After a spurious-wake pulse or a cancelled window, pd_bit stays 0 and no further pulse occurs until pd_req is written again. A later pd_req sets pd_bit again.
- R10: A pd_req during the validation window or during the spurious-wake pulse is ignored: pd_bit stays 0 and the pulse timing of R6 and R7 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_raw | input | 1 | Raw bus line from the receiver, idle high |
| host_rdy | input | 1 | Host ready line, level-sensitive wake source |
| pd_req | input | 1 | One-cycle strobe from the host that sets the power-down flag |
| pd_bit | output | 1 | Power-down flag; clears by itself on wake-up |
| bus_filt | output | 1 | Glitch-filtered bus level |
| spur_wake | output | 1 | Spurious wake-up pulse to the host |

## Verification
The bench builds the block with CLK_PER_US=4 and keeps the default FILT_US=7, WIN_US=12, PULSE_US=2 and SYNC_STAGES=2. At four cycles per microsecond, the 48-cycle window and the 8-cycle pulse can be counted exactly cycle by cycle. The filter's 28-cycle threshold falls well inside the window, so both a cancelled window and an expired one can be reached. Sub-cycle bus glitches then exercise the asynchronous wake path separately from the sampled filter path.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
   typedef enum logic [1:0] {
      PW_RUN   = 2'd0,
      PW_DOWN  = 2'd1,
      PW_CHECK = 2'd2,
      PW_PULSE = 2'd3
   } pw_state_t;
endpackage

// File: rtl/pdw_tick.sv
module pdw_tick #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign tick = ~clr;
      end else begin : g_count
         localparam int CW = $clog2(CLK_PER_US);
         localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (clr)          cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = !clr && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/pdw_sync.sv
module pdw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
   end
   assign q = sh[STAGES-1];
endmodule

// File: rtl/pdw_edge_catch.sv
module pdw_edge_catch (
   input  logic bus_line,
   input  logic arm,
   output logic caught
);
   // Set by any falling bus edge while armed; held clear while disarmed.
   always_ff @(negedge bus_line or negedge arm) begin
      if (!arm) caught <= 1'b0;
      else      caught <= 1'b1;
   end
endmodule

// File: rtl/pdw_deglitch.sv
module pdw_deglitch #(
   parameter int FILT_US   = 7,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic tick,
   input  logic din,
   output logic dout
);
   generate
      if (FILTER_EN) begin : g_filter
         localparam int FW = $clog2(FILT_US + 1);
         localparam logic [FW-1:0] LAST = FW'(FILT_US - 1);
         logic [FW-1:0] run_cnt;
         logic          lvl;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl     <= 1'b1;
               run_cnt <= '0;
            end else if (hold) begin
               lvl     <= 1'b1;
               run_cnt <= '0;
            end else if (din == lvl) begin
               run_cnt <= '0;
            end else if (tick) begin
               if (run_cnt == LAST) begin
                  lvl     <= din;
                  run_cnt <= '0;
               end else begin
                  run_cnt <= run_cnt + 1'b1;
               end
            end
         end
         assign dout = lvl;
      end else begin : g_bypass
         logic lvl;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    lvl <= 1'b1;
            else if (hold) lvl <= 1'b1;
            else           lvl <= din;
         end
         assign dout = lvl;
      end
   endgenerate
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
   import pdw_pkg::*;
#(
   parameter int WIN_US   = 12,
   parameter int PULSE_US = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pd_req,
   input  logic wake_edge,
   input  logic wake_rdy,
   input  logic filt_lo,
   output logic pd_flag,
   output logic arm,
   output logic spur
);
   localparam int WW = $clog2(WIN_US + 1);
   localparam int PW = $clog2(PULSE_US + 1);
   localparam logic [WW-1:0] WIN_LAST = WW'(WIN_US - 1);
   localparam logic [PW-1:0] PUL_LAST = PW'(PULSE_US - 1);

   pw_state_t     state, nxt;
   logic [WW-1:0] win_cnt;
   logic [PW-1:0] pul_cnt;

   always_comb begin
      nxt = state;
      unique case (state)
         PW_RUN:   if (pd_req) nxt = PW_DOWN;
         PW_DOWN:  if (wake_edge || wake_rdy) nxt = PW_CHECK;
         PW_CHECK: begin
            if (filt_lo)                          nxt = PW_RUN;
            else if (tick && win_cnt == WIN_LAST) nxt = PW_PULSE;
         end
         PW_PULSE: if (tick && pul_cnt == PUL_LAST) nxt = PW_RUN;
         default:  nxt = PW_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PW_RUN;
         win_cnt <= '0;
         pul_cnt <= '0;
         pd_flag <= 1'b0;
         arm     <= 1'b0;
         spur    <= 1'b0;
      end else begin
         state   <= nxt;
         pd_flag <= (nxt == PW_DOWN);
         arm     <= (nxt == PW_DOWN);
         spur    <= (nxt == PW_PULSE);
         if (state == PW_CHECK && nxt == PW_CHECK) begin
            if (tick) win_cnt <= win_cnt + 1'b1;
         end else begin
            win_cnt <= '0;
         end
         if (state == PW_PULSE && nxt == PW_PULSE) begin
            if (tick) pul_cnt <= pul_cnt + 1'b1;
         end else begin
            pul_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/pdwake_monitor.sv
module pdwake_monitor #(
   parameter int CLK_PER_US  = 50,
   parameter int FILT_US     = 7,
   parameter int WIN_US      = 12,
   parameter int PULSE_US    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_raw,
   input  logic host_rdy,
   input  logic pd_req,
   output logic pd_bit,
   output logic bus_filt,
   output logic spur_wake
);
   generate
      if (CLK_PER_US < 1)  begin : g_bad_clk   $error("CLK_PER_US must be at least 1");  end
      if (FILT_US < 1)     begin : g_bad_filt  $error("FILT_US must be at least 1");     end
      if (WIN_US <= FILT_US) begin : g_bad_win $error("WIN_US must exceed FILT_US");     end
      if (PULSE_US < 1)    begin : g_bad_pul   $error("PULSE_US must be at least 1");    end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic tick, arm, caught, edge_s, rdy_s, bus_s;

   pdw_edge_catch u_catch (
      .bus_line (bus_raw),
      .arm      (arm),
      .caught   (caught)
   );

   pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_edge (
      .clk (clk), .rst_n (rst_n), .d (caught), .q (edge_s)
   );
   pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rdy (
      .clk (clk), .rst_n (rst_n), .d (host_rdy), .q (rdy_s)
   );
   pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bus (
      .clk (clk), .rst_n (rst_n), .d (bus_raw), .q (bus_s)
   );

   pdw_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk (clk), .rst_n (rst_n), .clr (pd_bit), .tick (tick)
   );

   pdw_deglitch #(.FILT_US(FILT_US), .FILTER_EN(FILTER_EN)) u_filt (
      .clk (clk), .rst_n (rst_n), .hold (pd_bit), .tick (tick),
      .din (bus_s), .dout (bus_filt)
   );

   pdw_ctrl #(.WIN_US(WIN_US), .PULSE_US(PULSE_US)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pd_req    (pd_req),
      .wake_edge (edge_s),
      .wake_rdy  (rdy_s),
      .filt_lo   (~bus_filt),
      .pd_flag   (pd_bit),
      .arm       (arm),
      .spur      (spur_wake)
   );
endmodule

// File: rtl/pdwake_monitor_chk.sv
module pdwake_monitor_chk #(
   parameter int CLK_PER_US = 50,
   parameter int WIN_US     = 12,
   parameter int PULSE_US   = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pd_bit,
   input logic bus_filt,
   input logic spur_wake
);
   localparam int WIN_CYC = WIN_US * CLK_PER_US;
   localparam int PUL_CYC = PULSE_US * CLK_PER_US;

   logic [19:0] since_wake, hi_cnt;
   logic        seen_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_wake <= '0;
         hi_cnt     <= '0;
         seen_low   <= 1'b0;
      end else begin
         if (pd_bit)                  since_wake <= '0;
         else if (since_wake != '1)   since_wake <= since_wake + 1'b1;
         hi_cnt   <= spur_wake ? hi_cnt + 1'b1 : '0;
         if (pd_bit)         seen_low <= 1'b0;
         else if (!bus_filt) seen_low <= 1'b1;
      end
   end

   a_r6_window_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spur_wake) |-> (since_wake == 20'(WIN_CYC)));
   a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      spur_wake |-> (hi_cnt < 20'(PUL_CYC)));
   a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spur_wake) |-> (hi_cnt == 20'(PUL_CYC)));
   a_r8_no_pulse_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spur_wake) |-> !seen_low);
   a_r9_awake_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      spur_wake |-> !pd_bit);
   a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_bit) |=> !pd_bit);
   a_r2_filter_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_bit && $past(pd_bit)) |-> bus_filt);
endmodule

bind pdwake_monitor pdwake_monitor_chk #(
   .CLK_PER_US (CLK_PER_US),
   .WIN_US     (WIN_US),
   .PULSE_US   (PULSE_US)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pd_bit    (pd_bit),
   .bus_filt  (bus_filt),
   .spur_wake (spur_wake)
);

// File: tb/sim_pdwake_monitor.sv
module sim_pdwake_monitor;
   localparam int N    = 4;
   localparam int WIN  = 12;
   localparam int PUL  = 2;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, bus_raw = 1'b1, host_rdy = 1'b0, pd_req = 1'b0;
   logic pd_bit, bus_filt, spur_wake;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   pdwake_monitor #(.CLK_PER_US(N), .FILT_US(7), .WIN_US(WIN),
                    .PULSE_US(PUL), .SYNC_STAGES(SYNC)) u0 (
      .clk (clk), .rst_n (rst_n), .bus_raw (bus_raw), .host_rdy (host_rdy),
      .pd_req (pd_req), .pd_bit (pd_bit), .bus_filt (bus_filt), .spur_wake (spur_wake)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic enter_pd();
      @(negedge clk) pd_req = 1'b1;
      @(negedge clk) pd_req = 1'b0;
   endtask

   task automatic wait_fall(output int n);
      n = 0;
      while (pd_bit && n < 50) begin @(negedge clk); n++; end
   endtask

   // Called right after pd_bit is seen low; poke drives pd_req inside the window and pulse.
   task automatic measure(input bit poke, output int c, output int w, output bit pd_seen);
      c = 0; w = 0; pd_seen = 1'b0;
      while (!spur_wake && c < 400) begin
         @(negedge clk); c++;
         if (pd_bit) pd_seen = 1'b1;
         pd_req = poke && (c == 10);
      end
      while (spur_wake && w < 400) begin
         @(negedge clk); w++;
         if (pd_bit) pd_seen = 1'b1;
         pd_req = poke && (w == 2);
      end
      pd_req = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(pd_bit == 1'b0 && spur_wake == 1'b0, "R1", "pd/spur in reset", {pd_bit, spur_wake}, 0);
      chk(bus_filt == 1'b1, "R1", "filter idle in reset", bus_filt, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pd_bit == 1'b0 && spur_wake == 1'b0, "R1", "pd/spur after reset", {pd_bit, spur_wake}, 0);
   endtask

   task automatic t_filter();
      bit dropped = 1'b0;
      bus_raw = 1'b0;
      repeat (20) @(negedge clk);
      bus_raw = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!bus_filt) dropped = 1'b1;
      end
      chk(!dropped, "R5", "5us low pulse rejected", dropped, 0);
      bus_raw = 1'b0;
      repeat (44) @(negedge clk);
      chk(bus_filt == 1'b0, "R5", "11us low accepted", bus_filt, 0);
      bus_raw = 1'b1;
      repeat (44) @(negedge clk);
      chk(bus_filt == 1'b1, "R5", "return high accepted", bus_filt, 1);
   endtask

   task automatic t_hold_pd();
      bit woke = 1'b0, low = 1'b0;
      enter_pd();
      chk(pd_bit == 1'b1, "R2", "pd_bit set by strobe", pd_bit, 1);
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (!pd_bit) woke = 1'b1;
         if (!bus_filt) low = 1'b1;
      end
      chk(!woke, "R2", "no wake while idle", woke, 0);
      chk(!low, "R2", "filter held high", low, 0);
   endtask

   task automatic t_glitch_wake();
      int n, c, w;
      bit pds, low = 1'b0;
      @(posedge clk);
      #5 bus_raw = 1'b0;
      #3 bus_raw = 1'b1;
      wait_fall(n);
      chk(n >= 1 && n <= SYNC + 3, "R3", "sub-cycle glitch wakes", n, SYNC + 2);
      measure(1'b0, c, w, pds);
      chk(c == WIN * N, "R6", "window after glitch", c, WIN * N);
      chk(w == PUL * N, "R7", "pulse width after glitch", w, PUL * N);
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (pd_bit || spur_wake) low = 1'b1;
      end
      chk(!low, "R9", "stays awake, no repeat pulse", low, 0);
   endtask

   task automatic t_rdy_entry();
      int n, c, w;
      bit pds;
      host_rdy = 1'b1;
      repeat (4) @(negedge clk);
      enter_pd();
      chk(pd_bit == 1'b1, "R4", "pd_bit set despite rdy high", pd_bit, 1);
      wait_fall(n);
      chk(n == 1, "R4", "immediate wake with rdy high", n, 1);
      host_rdy = 1'b0;
      measure(1'b1, c, w, pds);
      chk(!pds, "R10", "pd_req ignored in window and pulse", pds, 0);
      chk(c == WIN * N, "R10", "window unchanged by pd_req", c, WIN * N);
      chk(w == PUL * N, "R7", "pulse width after rdy wake", w, PUL * N);
      repeat (5) @(negedge clk);
      chk(pd_bit == 1'b0, "R10", "pd_bit still clear", pd_bit, 0);
   endtask

   task automatic t_rdy_late();
      int n, c, w;
      bit pds;
      enter_pd();
      repeat (30) @(negedge clk);
      chk(pd_bit == 1'b1, "R4", "still down before rdy", pd_bit, 1);
      host_rdy = 1'b1;
      wait_fall(n);
      chk(n >= 1 && n <= SYNC + 3, "R4", "rdy level wakes", n, SYNC + 1);
      host_rdy = 1'b0;
      measure(1'b0, c, w, pds);
      chk(c == WIN * N, "R6", "window after rdy wake", c, WIN * N);
   endtask

   task automatic t_cancel();
      int n;
      bit sp = 1'b0, low = 1'b0, pdh = 1'b0;
      enter_pd();
      @(negedge clk) bus_raw = 1'b0;
      wait_fall(n);
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (spur_wake) sp = 1'b1;
         if (!bus_filt) low = 1'b1;
         if (pd_bit) pdh = 1'b1;
      end
      chk(low, "R8", "filter saw real activity", low, 1);
      chk(!sp, "R8", "no pulse on real wake", sp, 0);
      chk(!pdh, "R9", "awake after cancelled window", pdh, 0);
      bus_raw = 1'b1;
      repeat (60) @(negedge clk);
      enter_pd();
      chk(pd_bit == 1'b1, "R9", "re-entry on new strobe", pd_bit, 1);
   endtask

   initial begin
      t_reset();
      t_filter();
      t_hold_pd();
      t_glitch_wake();
      t_rdy_entry();
      t_rdy_late();
      t_cancel();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule